// File: doc/BRIEF.md
# Data Storage Fault Entry Sequencer

This block commits the register state needed to enter the data storage fault handler. The load/store pipeline raises a one-cycle take strobe together with the fault details. These are the address of the faulting instruction, the data address, the current machine state word, and three qualifiers: store-class, byte-ordering and user-mode cache-lock violation. In the same cycle the block tells the pipeline to suppress the faulting instruction. On the next clock edge it loads the saved PC, the saved state, the fault syndrome, the fault address and the new machine state. It also registers the handler address.

The handler address is assembled from two software-programmed registers: the upper half of a vector base register, the middle field of a per-cause offset register, and a 16-byte alignment. The new machine state keeps three enable bits and clears every other bit. When an access straddles a page boundary and only the second page faults, the fault address is set to the first byte of that page. This keeps the reported address inside both the accessed range and the faulting page.

Top module: `dse_entry_seq`

## Requirements
- R1: `suppress_o` is high in exactly the cycles in which `take_i` is high, with no register delay.
- R2: On a clock edge with `take_i` high, `save_pc_o` loads `instr_ea_i`.
- R3: On a clock edge with `take_i` high, `save_state_o` loads the whole `mstate_i` word unchanged.
- R4: Syndrome bit 8 (store) is loaded from `is_store_i`.
- R5: Syndrome bit 2 (lock) is set only when `is_lockop_i` is high, machine state bit 14 (user mode) is 1 and machine state bit 26 (user cache-lock enable) is 0. Otherwise it is cleared.
- R6: Syndrome bit 15 (byte order) is loaded from `is_byteord_i`. Every syndrome bit other than 2, 8 and 15 is loaded as 0.
- R7: The new machine state `mstate_o` copies bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) from `mstate_i`. All other bits are 0.
- R8: `fault_addr_o` loads `data_ea_i` when `cross_hi_i` is low. When `cross_hi_i` is high it loads the first byte of the following 4 KiB page: upper 20 bits of `data_ea_i` plus one, low 12 bits zero.
- R9: `redirect_pc_o` loads `{vec_base_i[31:16], vec_off_i[15:4], 4'b0000}`. `redirect_vld_o` is high for exactly the one cycle after each edge on which `take_i` was high.
- R10: On an edge with `take_i` low, every registered output keeps its value, and `redirect_vld_o` is low.
- R11: A synchronous reset clears every registered output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_i | input | 1 | One-cycle strobe: take the data storage fault |
| instr_ea_i | input | 32 | Address of the faulting instruction |
| data_ea_i | input | 32 | Data address of the faulting access |
| cross_hi_i | input | 1 | Fault lies on the second page of a page-straddling access |
| mstate_i | input | 32 | Current machine state word |
| is_store_i | input | 1 | Faulting operation is a store or store-class cache operation |
| is_byteord_i | input | 1 | Fault is a byte-ordering fault |
| is_lockop_i | input | 1 | Faulting operation is a cache-lock operation |
| vec_base_i | input | 32 | Vector base register |
| vec_off_i | input | 32 | Data storage vector offset register |
| suppress_o | output | 1 | Suppress the faulting instruction |
| save_pc_o | output | 32 | Saved PC |
| save_state_o | output | 32 | Saved machine state |
| syndrome_o | output | 32 | Fault syndrome |
| fault_addr_o | output | 32 | Fault data address |
| mstate_o | output | 32 | New machine state |
| redirect_pc_o | output | 32 | Handler address |
| redirect_vld_o | output | 1 | Handler address valid (one-cycle pulse) |

## Verification
The bench takes faults with the store, byte-order and lock qualifiers one at a time and together. This shows that each syndrome bit follows only its own input and that undefined bits stay clear. The lock case is tried in all four combinations of user mode and cache-lock enable, which separates the three-term condition from any simpler one. Machine state words that are all ones, all zeros and alternating show which bits survive the mask. Page-straddling addresses, including one at the top of the address space, tell the next-page computation from a plain copy. Fault-free cycles between takes show that the outputs hold.

// File: rtl/dse_pkg.sv
package dse_pkg;
    parameter int unsigned DSE_XLEN = 32;

    typedef struct packed {
        logic [DSE_XLEN-1:0] save_pc;
        logic [DSE_XLEN-1:0] save_state;
        logic [DSE_XLEN-1:0] syndrome;
        logic [DSE_XLEN-1:0] fault_addr;
        logic [DSE_XLEN-1:0] mstate;
        logic [DSE_XLEN-1:0] redirect_pc;
        logic                redirect_vld;
    } dse_regs_t;
endpackage

// File: rtl/dse_syndrome_gen.sv
module dse_syndrome_gen
    import dse_pkg::*;
#(
    parameter int unsigned USER_POS   = 14,
    parameter int unsigned ULOCK_POS  = 26,
    parameter int unsigned SYN_ST_POS = 8,
    parameter int unsigned SYN_LK_POS = 2,
    parameter int unsigned SYN_BO_POS = 15
) (
    input  logic [DSE_XLEN-1:0] mstate,
    input  logic                is_store,
    input  logic                is_byteord,
    input  logic                is_lockop,
    output logic [DSE_XLEN-1:0] syndrome
);
    logic lock_viol;

    // lock violation: user mode with user cache-lock disabled
    assign lock_viol = is_lockop & mstate[USER_POS] & ~mstate[ULOCK_POS];

    always_comb begin
        syndrome             = '0;
        syndrome[SYN_ST_POS] = is_store;
        syndrome[SYN_LK_POS] = lock_viol;
        syndrome[SYN_BO_POS] = is_byteord;
    end
endmodule

// File: rtl/dse_state_mask.sv
module dse_state_mask
    import dse_pkg::*;
#(
    parameter int unsigned CRIT_POS = 17,
    parameter int unsigned MCHK_POS = 12,
    parameter int unsigned DBG_POS  = 9
) (
    input  logic [DSE_XLEN-1:0] cur_state,
    output logic [DSE_XLEN-1:0] new_state
);
    for (genvar i = 0; i < DSE_XLEN; i++) begin : g_bit
        if (i == CRIT_POS || i == MCHK_POS || i == DBG_POS) begin : g_keep
            assign new_state[i] = cur_state[i];
        end else begin : g_clear
            assign new_state[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dse_fault_addr.sv
module dse_fault_addr
    import dse_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic [DSE_XLEN-1:0] data_ea,
    input  logic                cross_hi,
    output logic [DSE_XLEN-1:0] fault_addr
);
    localparam int unsigned PFN_W = DSE_XLEN - PAGE_BITS;

    logic [PFN_W-1:0] next_pfn;

    assign next_pfn   = data_ea[DSE_XLEN-1:PAGE_BITS] + PFN_W'(1);
    assign fault_addr = cross_hi ? {next_pfn, {PAGE_BITS{1'b0}}} : data_ea;
endmodule

// File: rtl/dse_vector_calc.sv
module dse_vector_calc
    import dse_pkg::*;
#(
    parameter int unsigned VEC_BASE_BITS = 16,
    parameter int unsigned VEC_ALIGN     = 4
) (
    input  logic [DSE_XLEN-1:0] vec_base,
    input  logic [DSE_XLEN-1:0] vec_off,
    output logic [DSE_XLEN-1:0] handler_pc
);
    localparam int unsigned OFF_HI = DSE_XLEN - VEC_BASE_BITS - 1;

    assign handler_pc = {vec_base[DSE_XLEN-1 -: VEC_BASE_BITS],
                         vec_off[OFF_HI:VEC_ALIGN],
                         {VEC_ALIGN{1'b0}}};
endmodule

// File: rtl/dse_entry_seq.sv
module dse_entry_seq
    import dse_pkg::*;
#(
    parameter int unsigned PAGE_BITS     = 12,
    parameter int unsigned VEC_BASE_BITS = 16,
    parameter int unsigned VEC_ALIGN     = 4,
    parameter int unsigned CRIT_POS      = 17,
    parameter int unsigned MCHK_POS      = 12,
    parameter int unsigned DBG_POS       = 9,
    parameter int unsigned USER_POS      = 14,
    parameter int unsigned ULOCK_POS     = 26,
    parameter int unsigned SYN_ST_POS    = 8,
    parameter int unsigned SYN_LK_POS    = 2,
    parameter int unsigned SYN_BO_POS    = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take_i,
    input  logic [DSE_XLEN-1:0] instr_ea_i,
    input  logic [DSE_XLEN-1:0] data_ea_i,
    input  logic                cross_hi_i,
    input  logic [DSE_XLEN-1:0] mstate_i,
    input  logic                is_store_i,
    input  logic                is_byteord_i,
    input  logic                is_lockop_i,
    input  logic [DSE_XLEN-1:0] vec_base_i,
    input  logic [DSE_XLEN-1:0] vec_off_i,
    output logic                suppress_o,
    output logic [DSE_XLEN-1:0] save_pc_o,
    output logic [DSE_XLEN-1:0] save_state_o,
    output logic [DSE_XLEN-1:0] syndrome_o,
    output logic [DSE_XLEN-1:0] fault_addr_o,
    output logic [DSE_XLEN-1:0] mstate_o,
    output logic [DSE_XLEN-1:0] redirect_pc_o,
    output logic                redirect_vld_o
);
    dse_regs_t regs_d, regs_q;

    logic [DSE_XLEN-1:0] syn_w, mask_w, fa_w, vec_w;

    dse_syndrome_gen #(
        .USER_POS  (USER_POS),
        .ULOCK_POS (ULOCK_POS),
        .SYN_ST_POS(SYN_ST_POS),
        .SYN_LK_POS(SYN_LK_POS),
        .SYN_BO_POS(SYN_BO_POS)
    ) u_syn (
        .mstate    (mstate_i),
        .is_store  (is_store_i),
        .is_byteord(is_byteord_i),
        .is_lockop (is_lockop_i),
        .syndrome  (syn_w)
    );

    dse_state_mask #(
        .CRIT_POS(CRIT_POS),
        .MCHK_POS(MCHK_POS),
        .DBG_POS (DBG_POS)
    ) u_mask (
        .cur_state(mstate_i),
        .new_state(mask_w)
    );

    dse_fault_addr #(
        .PAGE_BITS(PAGE_BITS)
    ) u_fa (
        .data_ea   (data_ea_i),
        .cross_hi  (cross_hi_i),
        .fault_addr(fa_w)
    );

    dse_vector_calc #(
        .VEC_BASE_BITS(VEC_BASE_BITS),
        .VEC_ALIGN    (VEC_ALIGN)
    ) u_vec (
        .vec_base  (vec_base_i),
        .vec_off   (vec_off_i),
        .handler_pc(vec_w)
    );

    // next-state computation
    always_comb begin
        regs_d              = regs_q;
        regs_d.redirect_vld = 1'b0;
        if (take_i) begin
            regs_d.save_pc      = instr_ea_i;
            regs_d.save_state   = mstate_i;
            regs_d.syndrome     = syn_w;
            regs_d.fault_addr   = fa_w;
            regs_d.mstate       = mask_w;
            regs_d.redirect_pc  = vec_w;
            regs_d.redirect_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign suppress_o     = take_i;
    assign save_pc_o      = regs_q.save_pc;
    assign save_state_o   = regs_q.save_state;
    assign syndrome_o     = regs_q.syndrome;
    assign fault_addr_o   = regs_q.fault_addr;
    assign mstate_o       = regs_q.mstate;
    assign redirect_pc_o  = regs_q.redirect_pc;
    assign redirect_vld_o = regs_q.redirect_vld;
endmodule

// File: rtl/dse_checker.sv
module dse_checker
    import dse_pkg::*;
#(
    parameter int unsigned VEC_ALIGN  = 4,
    parameter int unsigned CRIT_POS   = 17,
    parameter int unsigned MCHK_POS   = 12,
    parameter int unsigned DBG_POS    = 9,
    parameter int unsigned USER_POS   = 14,
    parameter int unsigned ULOCK_POS  = 26,
    parameter int unsigned SYN_ST_POS = 8,
    parameter int unsigned SYN_LK_POS = 2,
    parameter int unsigned SYN_BO_POS = 15
) (
    input logic                clk,
    input logic                rst,
    input logic                take_i,
    input logic [DSE_XLEN-1:0] instr_ea_i,
    input logic [DSE_XLEN-1:0] mstate_i,
    input logic                is_lockop_i,
    input logic [DSE_XLEN-1:0] save_pc_o,
    input logic [DSE_XLEN-1:0] save_state_o,
    input logic [DSE_XLEN-1:0] syndrome_o,
    input logic [DSE_XLEN-1:0] fault_addr_o,
    input logic [DSE_XLEN-1:0] mstate_o,
    input logic [DSE_XLEN-1:0] redirect_pc_o,
    input logic                redirect_vld_o
);
    localparam logic [DSE_XLEN-1:0] KEEP_MASK =
        (DSE_XLEN'(1) << CRIT_POS) | (DSE_XLEN'(1) << MCHK_POS) | (DSE_XLEN'(1) << DBG_POS);
    localparam logic [DSE_XLEN-1:0] SYN_MASK =
        (DSE_XLEN'(1) << SYN_ST_POS) | (DSE_XLEN'(1) << SYN_LK_POS) | (DSE_XLEN'(1) << SYN_BO_POS);

    assert_savepc_R2: assert property (@(posedge clk) disable iff (rst)
        take_i |=> save_pc_o == $past(instr_ea_i));

    assert_savestate_R3: assert property (@(posedge clk) disable iff (rst)
        take_i |=> save_state_o == $past(mstate_i));

    assert_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (take_i && is_lockop_i && mstate_i[USER_POS] && !mstate_i[ULOCK_POS])
        |=> syndrome_o[SYN_LK_POS]);

    assert_synclean_R6: assert property (@(posedge clk) disable iff (rst)
        (syndrome_o & ~SYN_MASK) == '0);

    assert_stateclean_R7: assert property (@(posedge clk) disable iff (rst)
        (mstate_o & ~KEEP_MASK) == '0);

    assert_vecalign_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o |-> redirect_pc_o[VEC_ALIGN-1:0] == '0);

    assert_vldpulse_R9: assert property (@(posedge clk) disable iff (rst)
        take_i |=> redirect_vld_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ($stable(save_pc_o) && $stable(save_state_o) && $stable(syndrome_o)
                     && $stable(fault_addr_o) && $stable(mstate_o)
                     && $stable(redirect_pc_o) && !redirect_vld_o));
endmodule

bind dse_entry_seq dse_checker #(
    .VEC_ALIGN (VEC_ALIGN),
    .CRIT_POS  (CRIT_POS),
    .MCHK_POS  (MCHK_POS),
    .DBG_POS   (DBG_POS),
    .USER_POS  (USER_POS),
    .ULOCK_POS (ULOCK_POS),
    .SYN_ST_POS(SYN_ST_POS),
    .SYN_LK_POS(SYN_LK_POS),
    .SYN_BO_POS(SYN_BO_POS)
) u_dse_checker (
    .clk           (clk),
    .rst           (rst),
    .take_i        (take_i),
    .instr_ea_i    (instr_ea_i),
    .mstate_i      (mstate_i),
    .is_lockop_i   (is_lockop_i),
    .save_pc_o     (save_pc_o),
    .save_state_o  (save_state_o),
    .syndrome_o    (syndrome_o),
    .fault_addr_o  (fault_addr_o),
    .mstate_o      (mstate_o),
    .redirect_pc_o (redirect_pc_o),
    .redirect_vld_o(redirect_vld_o)
);

// File: tb/dse_entry_seq_bench.sv
module dse_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        take_i;
    logic [31:0] instr_ea_i, data_ea_i, mstate_i, vec_base_i, vec_off_i;
    logic        cross_hi_i, is_store_i, is_byteord_i, is_lockop_i;
    logic        suppress_o, redirect_vld_o;
    logic [31:0] save_pc_o, save_state_o, syndrome_o, fault_addr_o, mstate_o, redirect_pc_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dse_entry_seq u_dse_entry_seq (
        .clk(clk), .rst(rst), .take_i(take_i),
        .instr_ea_i(instr_ea_i), .data_ea_i(data_ea_i), .cross_hi_i(cross_hi_i),
        .mstate_i(mstate_i), .is_store_i(is_store_i), .is_byteord_i(is_byteord_i),
        .is_lockop_i(is_lockop_i), .vec_base_i(vec_base_i), .vec_off_i(vec_off_i),
        .suppress_o(suppress_o), .save_pc_o(save_pc_o), .save_state_o(save_state_o),
        .syndrome_o(syndrome_o), .fault_addr_o(fault_addr_o), .mstate_o(mstate_o),
        .redirect_pc_o(redirect_pc_o), .redirect_vld_o(redirect_vld_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_syn(logic [31:0] ms, logic st, logic bo, logic lk);
        logic [31:0] s = '0;
        s[8]  = st;
        s[2]  = lk & ms[14] & ~ms[26];
        s[15] = bo;
        return s;
    endfunction

    function automatic logic [31:0] exp_ms(logic [31:0] ms);
        return ms & 32'h0002_1200;
    endfunction

    function automatic logic [31:0] exp_fa(logic [31:0] ea, logic hi);
        return hi ? {ea[31:12] + 20'd1, 12'h000} : ea;
    endfunction

    // apply one fault and check every registered result
    task automatic take_fault(input string tag, input logic [31:0] pc, input logic [31:0] ea,
                              input logic hi, input logic [31:0] ms, input logic st,
                              input logic bo, input logic lk, input logic [31:0] vb,
                              input logic [31:0] vo);
        @(negedge clk);
        instr_ea_i = pc; data_ea_i = ea; cross_hi_i = hi; mstate_i = ms;
        is_store_i = st; is_byteord_i = bo; is_lockop_i = lk;
        vec_base_i = vb; vec_off_i = vo; take_i = 1'b1;
        #1 chk({tag, " R1 suppress"}, {31'd0, suppress_o}, 32'd1);
        @(negedge clk);
        take_i = 1'b0;
        #1 chk({tag, " R1 suppress low"}, {31'd0, suppress_o}, 32'd0);
        chk({tag, " R2 save_pc"}, save_pc_o, pc);
        chk({tag, " R3 save_state"}, save_state_o, ms);
        chk({tag, " R4/R5/R6 syndrome"}, syndrome_o, exp_syn(ms, st, bo, lk));
        chk({tag, " R7 mstate"}, mstate_o, exp_ms(ms));
        chk({tag, " R8 fault_addr"}, fault_addr_o, exp_fa(ea, hi));
        chk({tag, " R9 redirect_pc"}, redirect_pc_o, {vb[31:16], vo[15:4], 4'h0});
        chk({tag, " R9 redirect_vld"}, {31'd0, redirect_vld_o}, 32'd1);
    endtask

    // idle cycles with scrambled inputs: everything holds
    task automatic t_hold_R10();
        logic [31:0] pc0, ss0, sy0, fa0, ms0, rp0;
        pc0 = save_pc_o; ss0 = save_state_o; sy0 = syndrome_o;
        fa0 = fault_addr_o; ms0 = mstate_o; rp0 = redirect_pc_o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            instr_ea_i = 32'hDEAD_0000 + i; data_ea_i = ~data_ea_i; mstate_i = ~mstate_i;
            is_store_i = ~is_store_i; is_byteord_i = ~is_byteord_i; is_lockop_i = ~is_lockop_i;
            vec_base_i = ~vec_base_i; vec_off_i = ~vec_off_i; cross_hi_i = ~cross_hi_i;
        end
        @(negedge clk);
        chk("R10 hold save_pc", save_pc_o, pc0);
        chk("R10 hold save_state", save_state_o, ss0);
        chk("R10 hold syndrome", syndrome_o, sy0);
        chk("R10 hold fault_addr", fault_addr_o, fa0);
        chk("R10 hold mstate", mstate_o, ms0);
        chk("R10 hold redirect_pc", redirect_pc_o, rp0);
        chk("R10 vld low", {31'd0, redirect_vld_o}, 32'd0);
    endtask

    task automatic t_reset_R11();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 save_pc", save_pc_o, '0);
        chk("R11 save_state", save_state_o, '0);
        chk("R11 syndrome", syndrome_o, '0);
        chk("R11 fault_addr", fault_addr_o, '0);
        chk("R11 mstate", mstate_o, '0);
        chk("R11 redirect_pc", redirect_pc_o, '0);
        chk("R11 vld", {31'd0, redirect_vld_o}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_lock_R5();
        for (int c = 0; c < 4; c++) begin
            logic [31:0] ms = 32'h0;
            ms[14] = c[0];
            ms[26] = c[1];
            take_fault("lock", 32'h0000_1000 + c * 4, 32'h2000_0010, 1'b0, ms,
                       1'b0, 1'b0, 1'b1, 32'h1234_0000, 32'h0000_0120);
            chk("R5 lock bit", {31'd0, syndrome_o[2]}, {31'd0, (c == 1)});
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; take_i = 1'b0;
        instr_ea_i = '0; data_ea_i = '0; cross_hi_i = 1'b0; mstate_i = '0;
        is_store_i = 1'b0; is_byteord_i = 1'b0; is_lockop_i = 1'b0;
        vec_base_i = '0; vec_off_i = '0;
        t_reset_R11();
        // basic load fault, all enables set
        take_fault("load", 32'h0040_0100, 32'h1000_0ABC, 1'b0, 32'hFFFF_FFFF,
                   1'b0, 1'b0, 1'b0, 32'hFFF0_0000, 32'h0000_0FF0);
        t_hold_R10();
        take_fault("store R4", 32'h0040_0104, 32'h1000_0004, 1'b0, 32'h0000_0000,
                   1'b1, 1'b0, 1'b0, 32'hABCD_5678, 32'hFFFF_FFFF);
        take_fault("byteord R6", 32'h0040_0108, 32'h3000_0FFE, 1'b0, 32'hAAAA_AAAA,
                   1'b0, 1'b1, 1'b0, 32'h5555_AAAA, 32'h0000_0A5F);
        take_fault("all R6", 32'h0040_010C, 32'h3000_0FFE, 1'b0, 32'h5555_5555,
                   1'b1, 1'b1, 1'b1, 32'h8000_0001, 32'h0000_0800);
        t_lock_R5();
        take_fault("cross R8", 32'h0040_0110, 32'h7000_AFFD, 1'b1, 32'h0002_1200,
                   1'b1, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0010);
        take_fault("wrap R8", 32'h0040_0114, 32'hFFFF_FFFE, 1'b1, 32'h0000_4000,
                   1'b0, 1'b0, 1'b0, 32'h0002_0000, 32'h0000_0020);
        t_hold_R10();
        t_reset_R11();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule